// File: doc/BRIEF.md
# Double-Buffered PWM Timer Channel

This block is one timer channel that produces a pulse-width-modulated output. Software writes a period value and a threshold value into two buffer registers. The channel moves these values into its working down-counter and comparator only when a period ends. Software can also force the move at once by setting and then clearing a load bit in the control register. An external prescaler supplies a single-cycle `tick`. The counter steps down by one on each tick. At the bottom of each period the channel gives a one-cycle pulse that an interrupt controller can use.

When software clears the run bit, the output does not fall back to its idle level. It keeps the level it was showing. This has a known consequence for software. Suppose the channel runs at full duty and software writes a zero threshold and then stops the channel before the next period boundary. The output then stays active, because the new threshold never reached the comparator. A forced load between the two writes avoids this.

Top module: `pwm_timer_chan`

## Requirements
- R1: Values written to the period buffer (address 0x4) or the threshold buffer (address 0x8) while the channel runs do not change the output or the live count. They take effect only on the tick at which the live count is 0, where both are copied into the working registers.
- R2: While control bit 1 (forced load) is 1, every clock copies both buffers into the working registers, and the counter does not step on ticks. After the bit is cleared, counting resumes from the loaded period value.
- R3: With control bit 0 (run) at 0 and bit 1 at 0, the output level and the live count stay frozen, even when ticks arrive.
- R4: A period lasts the period value plus one ticks, with live counts N, N-1, ..., 0. On the tick taken at live count 0, `period_end` is 1 for exactly one clock, one clock after that tick.
- R5: The output, before inversion, is active (1) while the live count is below the threshold. A threshold of all ones gives an active output for the whole period, and a threshold of 0 gives an output that is never active.
- R6: With control bit 3 (auto-reload) at 1, the channel reloads and keeps running. With bit 3 at 0, the tick at count 0 clears the run bit, and the count and output level then stay as they were.
- R7: Control bit 2 inverts `pwm_out`.
- R8: After reset, all registers read 0, `pwm_out` is 0 and `period_end` is 0. Address 0x0 reads the control bits, and address 0xC reads the live count.
- R9: At full duty, writing a zero threshold and then clearing the run bit leaves the output active. A forced load between those two writes makes the output inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register byte address |
| wdata | input | W | Write data |
| rdata | output | W | Read data for `addr`, combinational |
| tick | input | 1 | Prescaled count enable, one clock wide |
| pwm_out | output | 1 | PWM output |
| period_end | output | 1 | One-clock pulse at the bottom of each period |

## Verification
The bench targets these corner cases:
- **Stuck-high race.** A design that moved buffers on every write, or that dropped the output on disable, would read low after the zero-threshold write and disable.
- **Mid-period threshold change.** Any early transfer shows up at once as a wrong level.
- **Threshold extremes and short periods.** Thresholds of all ones, zero, and above the period are used, together with a period of length one. These catch off-by-one errors in the compare and in the period length.
- **One-shot stop and held load bit.** These catch a counter that keeps running when it should be frozen.

// File: rtl/pwm_timer_chan.sv
module pwm_timer_chan #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [3:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic         tick,
  output logic         pwm_out,
  output logic         period_end
);
  localparam logic [W-1:0] ALL1 = '1;
  localparam logic [3:0] A_CTRL = 4'h0, A_PER = 4'h4, A_THR = 4'h8, A_LIVE = 4'hC;

  logic         run_b, load_b, inv_b, arl_b;
  logic [W-1:0] per_buf, thr_buf, cnt_q, thr_q;
  logic         lvl_q, pe_q;

  wire active  = run_b & ~load_b;
  wire at_zero = (cnt_q == '0);
  wire wrap    = active & tick & at_zero;
  wire lvl_act = (thr_q == ALL1) | (cnt_q < thr_q);
  wire lvl_buf = (thr_buf == ALL1) | (per_buf < thr_buf);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_b <= 1'b0; load_b <= 1'b0; inv_b <= 1'b0; arl_b <= 1'b0;
      per_buf <= '0; thr_buf <= '0; cnt_q <= '0; thr_q <= '0;
      lvl_q <= 1'b0; pe_q <= 1'b0;
    end else begin
      pe_q <= wrap;
      if (load_b) begin
        cnt_q <= per_buf;
        thr_q <= thr_buf;
        lvl_q <= lvl_buf;
      end else if (active) begin
        lvl_q <= lvl_act;
        if (tick) begin
          if (!at_zero) cnt_q <= cnt_q - 1'b1;
          else if (arl_b) begin
            cnt_q <= per_buf;
            thr_q <= thr_buf;
          end else run_b <= 1'b0;
        end
      end
      if (wr_en) begin
        case (addr)
          A_CTRL: {arl_b, inv_b, load_b, run_b} <= wdata[3:0];
          A_PER:  per_buf <= wdata;
          A_THR:  thr_buf <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdata = {{(W-4){1'b0}}, arl_b, inv_b, load_b, run_b};
      A_PER:   rdata = per_buf;
      A_THR:   rdata = thr_buf;
      A_LIVE:  rdata = cnt_q;
      default: rdata = '0;
    endcase
  end

  assign pwm_out    = lvl_q ^ inv_b;
  assign period_end = pe_q;

  p_no_early_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !(tick && at_zero)) |=> (thr_q == $past(thr_q)));

  p_forced_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_b |=> (cnt_q == $past(per_buf) && thr_q == $past(thr_buf)));

  p_frozen_when_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_b && !load_b) |=> ($stable(lvl_q) && $stable(cnt_q)));

  p_pulse_at_bottom_r4: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |-> ($past(cnt_q) == '0 && $past(tick)));

  p_full_duty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && thr_q == ALL1) |=> lvl_q);

  p_one_shot_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !arl_b && !wr_en) |=> !run_b);
endmodule

// File: tb/pwm_timer_chan_bench.sv
module pwm_timer_chan_bench;
  localparam int W = 16;
  logic clk = 0, rst_n = 0, wr_en = 0, tick = 0;
  logic [3:0] addr = 0;
  logic [W-1:0] wdata = 0, rdata;
  logic pwm_out, period_end;
  int nchk = 0, nfail = 0;
  logic pe_seen;
  logic [W-1:0] rv;

  pwm_timer_chan #(.W(W)) u_pwm_timer_chan (.clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .tick(tick), .pwm_out(pwm_out),
    .period_end(period_end));

  always #10 clk = ~clk;

  // {period, threshold, expected active ticks per period}
  localparam logic [47:0] VEC [7] = '{
    {16'd5, 16'd2, 16'd2}, {16'd5, 16'd0, 16'd0}, {16'd5, 16'hFFFF, 16'd6},
    {16'd3, 16'd4, 16'd4}, {16'd7, 16'd3, 16'd3}, {16'd0, 16'd1, 16'd1},
    {16'd9, 16'd10, 16'd10}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [W-1:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [W-1:0] d);
    addr = a; #1 d = rdata;
  endtask

  task automatic do_tick;
    tick = 1; @(negedge clk); tick = 0; pe_seen = period_end;
    @(negedge clk);
  endtask

  task automatic load(input logic [W-1:0] p, input logic [W-1:0] t, input logic [3:0] c);
    wr(4'h4, p); wr(4'h8, t); wr(4'h0, 4'b0010); wr(4'h0, c);
  endtask

  initial begin
    #4_000_000;
    nfail++;
    $display("FAIL watchdog: actual hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R8 reset state
    chk("R8 pwm_out", pwm_out, 0);
    chk("R8 period_end", period_end, 0);
    for (int a = 0; a < 16; a += 4) begin
      rd(a[3:0], rv); chk("R8 reg reset", rv, 0);
    end

    // R4 R5 duty and period per vector
    for (int i = 0; i < 7; i++) begin
      logic [W-1:0] p, t, e;
      int highs, pes;
      {p, t, e} = VEC[i];
      load(p, t, 4'b1001);
      highs = pwm_out; pes = 0;
      for (int k = 0; k < p; k++) begin
        do_tick; highs += pwm_out; pes += pe_seen;
      end
      chk("R5 active ticks", highs, e);
      chk("R4 no pulse before bottom", pes, 0);
      do_tick;
      chk("R4 pulse at bottom", pe_seen, 1);
      chk("R4 pulse one clock", period_end, 0);
      rd(4'hC, rv); chk("R6 reload count", rv, p);
      wr(4'h0, 0);
    end

    // R8 control readback
    wr(4'h0, 4'b1001); rd(4'h0, rv); chk("R8 ctrl read", rv, 9);
    wr(4'h0, 0);

    // R1 mid-period threshold write
    load(5, 0, 4'b1001);
    do_tick; do_tick;
    wr(4'h8, 16'hFFFF);
    chk("R1 no early effect", pwm_out, 0);
    rd(4'hC, rv); chk("R1 live count", rv, 3);
    for (int k = 0; k < 3; k++) do_tick;
    chk("R1 still old threshold", pwm_out, 0);
    do_tick;
    chk("R1 new threshold at boundary", pwm_out, 1);
    wr(4'h0, 0);

    // R9 race without forced load
    load(5, 16'hFFFF, 4'b1001);
    do_tick; do_tick;
    wr(4'h8, 0); wr(4'h0, 0);
    for (int k = 0; k < 4; k++) do_tick;
    chk("R9 stuck active", pwm_out, 1);
    rd(4'hC, rv); chk("R3 count frozen", rv, 3);
    // R9 with forced load
    load(5, 16'hFFFF, 4'b1001);
    do_tick; do_tick;
    wr(4'h8, 0); wr(4'h0, 4'b1011); wr(4'h0, 4'b1001); wr(4'h0, 0);
    for (int k = 0; k < 4; k++) do_tick;
    chk("R9 inactive after load", pwm_out, 0);

    // R2 held load bit
    wr(4'h4, 7); wr(4'h8, 2); wr(4'h0, 4'b1011);
    for (int k = 0; k < 3; k++) do_tick;
    rd(4'hC, rv); chk("R2 count held", rv, 7);
    wr(4'h0, 4'b1001); do_tick;
    rd(4'hC, rv); chk("R2 resumes", rv, 6);
    wr(4'h0, 0);

    // R6 one-shot
    load(2, 1, 4'b0001);
    do_tick; do_tick;
    chk("R6 active at zero", pwm_out, 1);
    do_tick;
    chk("R6 pulse", pe_seen, 1);
    rd(4'h0, rv); chk("R6 run cleared", rv, 0);
    for (int k = 0; k < 3; k++) do_tick;
    rd(4'hC, rv); chk("R6 count stays", rv, 0);
    chk("R6 level held", pwm_out, 1);

    // R7 invert
    load(3, 0, 4'b1101);
    chk("R7 inverted", pwm_out, 1);
    wr(4'h0, 4'b1001);
    chk("R7 normal", pwm_out, 0);
    wr(4'h0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule